// File: doc/BRIEF.md
# Bit-Serial Shift-and-Add Dot Product Unit

This block forms the inner product of sixteen activations with sixteen signed weights without any multiplier. Each activation is presented as a stream of terms, one term per cycle per lane. A term is a power-of-two position, called an offset, plus a sign. A lane's weight is shifted left by the offset of its current term and is added to or subtracted from a shared accumulator through a single adder tree. A multiplication therefore costs as many cycles as the activation has terms, not as many as it has bits. A whole set of sixteen products costs as many cycles as the longest term stream among the lanes.

The host pulses `start` with all sixteen weights on `weights`. The unit latches them and clears the accumulator. Each lane then accepts its terms through its own valid/ready handshake. A lane must send at least one beat, and it marks its final beat with `term_last`. A lane whose activation has no terms sends one beat with `term_void` and `term_last` set. When every lane has delivered its final beat, `done` pulses for one cycle and `result` holds the inner product until the next accepted start.

Back-pressure rules: a beat transfers on a rising edge where both `term_valid` and `term_ready` for that lane are high. While `term_valid` is high and `term_ready` is low, the producer holds the beat unchanged. `term_ready` is high only while a job runs and that lane has not yet delivered its final beat. A lane may insert bubbles by dropping `term_valid`, and doing so only lengthens the job.

Top module: `sa_dot_unit`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and every `term_ready` bit is 0.
- R2: A `start` sampled while no job runs latches `weights`, with lane i on bits [16i+15:16i]. It clears the accumulator, and every `term_ready` bit is 1 in the following cycle.
- R3: An accepted beat with `term_void`=0 and `term_neg`=0 adds the lane's weight, taken as signed two's complement, multiplied by 2^`term_off`. `term_off` for lane i is on bits [4i+3:4i] and covers 0 to 15. Accepted beats from all lanes in the same cycle are summed together.
- R4: An accepted beat with `term_neg`=1 subtracts the same shifted weight instead.
- R5: An accepted beat with `term_void`=1 adds nothing, but its `term_last` still ends the lane.
- R6: Once a lane's last beat is accepted, its `term_ready` stays 0 until the next job. Further valid beats on that lane leave `result` unchanged.
- R7: `done` is high for exactly one cycle, in the cycle after the edge that accepts the final outstanding last beat. `result` then holds its value while no job runs.
- R8: When every lane presents a beat every cycle, the number of cycles from the start edge to the `done` cycle equals the largest number of beats on any lane.
- R9: The accumulator wraps modulo 2^32.
- R10: `start` while a job runs is ignored. The running job keeps its latched weights and its timing.
- R11: `term_valid` while no job runs has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; weights are sampled with it |
| weights | input | 256 | Sixteen signed 16-bit weights, lane 0 in the low bits |
| term_valid | input | 16 | Per-lane beat valid |
| term_ready | output | 16 | Per-lane beat ready |
| term_off | input | 64 | Per-lane 4-bit shift amount |
| term_neg | input | 16 | Per-lane subtract flag |
| term_last | input | 16 | Per-lane final-beat flag |
| term_void | input | 16 | Per-lane empty beat (no contribution) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Accumulated inner product |

## Verification
A sweep of single-beat jobs walks all sixteen offsets across every lane, using extreme and mixed-sign weights with alternating signs. This separates shift and sign errors lane by lane. Jobs with unequal stream lengths show whether completion follows the longest lane and whether void beats are dropped. The same jobs with bubbles and with junk beats held on finished lanes test the handshake: a lane that accepts too early or too late changes the sum. Saturating weights at the top offset test the wrap. A start pulse during a run shows whether a new start disturbs a job already in progress.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int LANES_D = 16;
  localparam int WGT_W_D = 16;
  localparam int OFF_W_D = 4;
  localparam int ACC_W_D = 32;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sa_state_t;
endpackage

// File: rtl/sa_lane.sv
module sa_lane #(
  parameter int WGT_W = 16,
  parameter int OFF_W = 4,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [WGT_W-1:0] wgt_in,
  input  logic             valid,
  input  logic [OFF_W-1:0] off,
  input  logic             neg,
  input  logic             last,
  input  logic             void_i,
  output logic             ready,
  output logic             fire,
  output logic             fin,
  output logic [ACC_W-1:0] contrib
);
  localparam int SHW = WGT_W + (1 << OFF_W) - 1;

  logic [WGT_W-1:0] wgt_q;
  logic             fin_q;
  logic [SHW-1:0]   wext;
  logic [SHW-1:0]   shv;
  logic [ACC_W-1:0] mag;

  assign ready = run && !fin_q;
  assign fire  = valid && ready;
  assign fin   = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgt_q <= '0;
      fin_q <= 1'b0;
    end else if (load) begin
      wgt_q <= wgt_in;
      fin_q <= 1'b0;
    end else if (fire && last) begin
      fin_q <= 1'b1;
    end
  end

  // sign extend, shift, then widen to the accumulator (ACC_W must exceed SHW)
  always_comb begin
    wext = {{(SHW-WGT_W){wgt_q[WGT_W-1]}}, wgt_q};
    shv  = wext << off;
    mag  = {{(ACC_W-SHW){shv[SHW-1]}}, shv};
    if (!fire || void_i) contrib = '0;
    else if (neg)        contrib = ACC_W'(0) - mag;
    else                 contrib = mag;
  end

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && !load) |=> !ready) else $error("lane reopened after last"); // R6
  AST_LOAD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !run) |=> !fin) else $error("lane not rearmed on start"); // R2
endmodule

// File: rtl/sa_addtree.sv
module sa_addtree #(
  parameter int N = 16,
  parameter int W = 32
) (
  input  logic [N*W-1:0] in_flat,
  output logic [W-1:0]   sum
);
  localparam int NP = 1 << $clog2(N);

  logic [W-1:0] nd [1:2*NP-1];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      if (i < N) nd[NP+i] = in_flat[i*W +: W];
      else       nd[NP+i] = '0;
    end
    for (int j = NP-1; j >= 1; j--) begin
      nd[j] = nd[2*j] + nd[2*j+1];
    end
  end

  assign sum = nd[1];
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl #(
  parameter int LANES = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LANES-1:0] fire_v,
  input  logic [LANES-1:0] last_v,
  input  logic [LANES-1:0] fin_v,
  input  logic [ACC_W-1:0] sum,
  output logic             load,
  output logic             run,
  output logic [ACC_W-1:0] acc,
  output logic             done
);
  import sa_pkg::*;

  sa_state_t        st_q;
  logic             ending;
  logic [ACC_W-1:0] acc_q;
  logic             done_q;

  assign run    = (st_q == ST_RUN);
  assign load   = start && (st_q == ST_IDLE);
  assign ending = run && (&(fin_v | (fire_v & last_v)));
  assign acc    = acc_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= ending;
      if (load) begin
        st_q  <= ST_RUN;
        acc_q <= '0;
      end else if (run) begin
        acc_q <= acc_q + sum;
        if (ending) st_q <= ST_IDLE;
      end
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc == '0)) else $error("accumulator not cleared"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(acc)) else $error("result moved while idle"); // R7
  AST_IDLE_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sum == '0)) else $error("idle lanes contribute"); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run && !ending) |=> run) else $error("start disturbed job"); // R10
endmodule

// File: rtl/sa_dot_unit.sv
module sa_dot_unit #(
  parameter int LANES = sa_pkg::LANES_D,
  parameter int WGT_W = sa_pkg::WGT_W_D,
  parameter int OFF_W = sa_pkg::OFF_W_D,
  parameter int ACC_W = sa_pkg::ACC_W_D
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LANES*WGT_W-1:0] weights,
  input  logic [LANES-1:0]       term_valid,
  output logic [LANES-1:0]       term_ready,
  input  logic [LANES*OFF_W-1:0] term_off,
  input  logic [LANES-1:0]       term_neg,
  input  logic [LANES-1:0]       term_last,
  input  logic [LANES-1:0]       term_void,
  output logic                   done,
  output logic [ACC_W-1:0]       result
);
  logic                   load;
  logic                   run;
  logic [LANES-1:0]       fire_v;
  logic [LANES-1:0]       fin_v;
  logic [LANES*ACC_W-1:0] contrib_flat;
  logic [ACC_W-1:0]       sum;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sa_lane #(.WGT_W(WGT_W), .OFF_W(OFF_W), .ACC_W(ACC_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .run     (run),
      .wgt_in  (weights[g*WGT_W +: WGT_W]),
      .valid   (term_valid[g]),
      .off     (term_off[g*OFF_W +: OFF_W]),
      .neg     (term_neg[g]),
      .last    (term_last[g]),
      .void_i  (term_void[g]),
      .ready   (term_ready[g]),
      .fire    (fire_v[g]),
      .fin     (fin_v[g]),
      .contrib (contrib_flat[g*ACC_W +: ACC_W])
    );
  end

  sa_addtree #(.N(LANES), .W(ACC_W)) u_tree (
    .in_flat (contrib_flat),
    .sum     (sum)
  );

  sa_ctrl #(.LANES(LANES), .ACC_W(ACC_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .fire_v (fire_v),
    .last_v (term_last),
    .fin_v  (fin_v),
    .sum    (sum),
    .load   (load),
    .run    (run),
    .acc    (result),
    .done   (done)
  );

  AST_DONE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (term_ready == '0)) else $error("ready while done"); // R6
  AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (term_ready == '0)) else $error("ready after run"); // R6
endmodule

// File: tb/tb_sa_dot_unit.sv
module tb_sa_dot_unit;
  localparam int L = 16;
  localparam int MAXB = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [L*16-1:0] weights = '0;
  logic [L-1:0]    term_valid = '0;
  logic [L-1:0]    term_ready;
  logic [L*4-1:0]  term_off = '0;
  logic [L-1:0]    term_neg = '0;
  logic [L-1:0]    term_last = '0;
  logic [L-1:0]    term_void = '0;
  logic            done;
  logic [31:0]     result;

  int nchk = 0;
  int nbad = 0;

  int          nb   [L];
  int          offs [L][MAXB];
  bit          negs [L][MAXB];
  bit          vds  [L][MAXB];
  logic [15:0] w    [L];
  int          ptr  [L];

  always #4 clk = ~clk;

  sa_dot_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .weights(weights),
    .term_valid(term_valid), .term_ready(term_ready), .term_off(term_off),
    .term_neg(term_neg), .term_last(term_last), .term_void(term_void),
    .done(done), .result(result)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [L*16-1:0] pack_w();
    logic [L*16-1:0] p;
    for (int l = 0; l < L; l++) p[l*16 +: 16] = w[l];
    return p;
  endfunction

  function automatic logic [31:0] expect_sum();
    longint a = 0;
    for (int l = 0; l < L; l++)
      for (int k = 0; k < nb[l]; k++)
        if (!vds[l][k]) begin
          longint t = longint'($signed(w[l])) * (longint'(1) << offs[l][k]);
          a += negs[l][k] ? -t : t;
        end
    return a[31:0];
  endfunction

  task automatic drive_beats(int cyc, bit stall, bit junk);
    for (int l = 0; l < L; l++) begin
      if (ptr[l] < nb[l] && !(stall && ((cyc + l) % 3 == 0))) begin
        term_valid[l] = 1'b1;
        term_off[l*4 +: 4] = 4'(offs[l][ptr[l]]);
        term_neg[l]  = negs[l][ptr[l]];
        term_void[l] = vds[l][ptr[l]];
        term_last[l] = (ptr[l] == nb[l] - 1);
      end else if (ptr[l] >= nb[l] && junk) begin
        term_valid[l] = 1'b1;
        term_off[l*4 +: 4] = 4'd15;
        term_neg[l] = 1'b0; term_void[l] = 1'b0; term_last[l] = 1'b0;
      end else begin
        term_valid[l] = 1'b0;
      end
    end
  endtask

  // runs one job; lat_exp < 0 skips the latency check (R8)
  task automatic run_job(string tag, bit stall, bit junk, bit restart, int lat_exp);
    logic [31:0]     exp;
    logic [31:0]     held;
    logic [L*16-1:0] saved;
    logic [L-1:0]    rdy;
    int              cyc;
    bit              fin;
    exp = expect_sum();
    saved = pack_w();
    for (int l = 0; l < L; l++) ptr[l] = 0;
    @(negedge clk);
    term_valid = '0;
    start = 1'b1;
    weights = saved;
    cyc = 0;
    fin = 0;
    while (!fin && cyc < 300) begin
      @(negedge clk);
      start = restart && (cyc == 2);
      if (restart && cyc == 2) weights = ~saved;
      if (cyc == 3) weights = saved;
      cyc++;
      if (cyc == 1) chk(term_ready == '1, {tag, " R2 ready after start"}, longint'(term_ready), 65535);
      if (done) begin
        fin = 1;
      end else begin
        drive_beats(cyc, stall, junk);
        #1 rdy = term_ready;
        @(posedge clk);
        for (int l = 0; l < L; l++) if (term_valid[l] && rdy[l]) ptr[l]++;
      end
    end
    chk(fin, {tag, " R7 done seen"}, longint'(fin), 1);
    chk(result == exp, {tag, " R3/R4/R5 result"}, longint'(result), longint'(exp));
    if (lat_exp >= 0) chk(cyc - 1 == lat_exp, {tag, " R8 latency"}, cyc - 1, lat_exp);
    held = result;
    for (int l = 0; l < L; l++) begin
      term_valid[l] = 1'b1; term_off[l*4 +: 4] = 4'd9;
      term_neg[l] = 1'b0; term_void[l] = 1'b0; term_last[l] = 1'b0;
    end
    @(negedge clk);
    chk(!done, {tag, " R7 done single pulse"}, longint'(done), 0);
    chk(term_ready == '0, {tag, " R6 ready low after job"}, longint'(term_ready), 0);
    @(negedge clk);
    chk(result == held, {tag, " R11 result held with idle valid"}, longint'(result), longint'(held));
    term_valid = '0;
  endtask

  task automatic set_varied(int seed);
    for (int l = 0; l < L; l++) begin
      nb[l] = (l % MAXB) + 1;
      w[l]  = 16'((l * 7919 + seed * 1237) ^ 16'h5a3c);
      for (int k = 0; k < MAXB; k++) begin
        offs[l][k] = (l * 3 + k * 5 + seed) % 16;
        negs[l][k] = ((k + l + seed) % 3 == 0);
        vds[l][k]  = (l == 5) || ((l == 9) && (k % 2 == 1));
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done, "R1 done after reset", longint'(done), 0);
    chk(result == 0, "R1 result after reset", longint'(result), 0);
    chk(term_ready == '0, "R1 ready after reset", longint'(term_ready), 0);

    // R11: valid with no job running
    term_valid = '1; term_off = '1;
    repeat (3) @(negedge clk);
    chk(term_ready == '0 && result == 0, "R11 idle valid ignored", longint'(result), 0);
    term_valid = '0;

    // offset sweep, single beat per lane (R3, R4)
    for (int o = 0; o < 16; o++) begin
      for (int l = 0; l < L; l++) begin
        nb[l] = 1;
        offs[l][0] = (o + l) % 16;
        negs[l][0] = ((o + l) % 2 == 1);
        vds[l][0]  = 1'b0;
        w[l] = (l == 0) ? 16'h8000 : (l == 1) ? 16'h7fff : 16'((l * 4099 + o * 257) ^ 16'h8001);
      end
      run_job($sformatf("sweep%0d", o), 0, 0, 0, 1);
    end

    // unequal lengths with void lanes (R5, R8)
    set_varied(1);
    run_job("varied", 0, 0, 0, MAXB);
    // bubbles and junk beats on finished lanes (R6)
    set_varied(2);
    run_job("stall_junk", 1, 1, 0, -1);
    // start while running (R10)
    set_varied(3);
    run_job("restart", 0, 1, 1, MAXB);

    // wrap modulo 2^32 (R9)
    for (int l = 0; l < L; l++) begin
      nb[l] = MAXB; w[l] = 16'h7fff;
      for (int k = 0; k < MAXB; k++) begin offs[l][k] = 15; negs[l][k] = 0; vds[l][k] = 0; end
    end
    run_job("wrap_pos", 0, 0, 0, MAXB);
    for (int l = 0; l < L; l++) begin
      nb[l] = 1; w[l] = 16'h8000; offs[l][0] = 15; negs[l][0] = 1; vds[l][0] = 0;
    end
    run_job("wrap_neg", 0, 0, 0, 1);

    // all lanes void: result zero (R5)
    for (int l = 0; l < L; l++) begin
      nb[l] = 2; w[l] = 16'h1234;
      for (int k = 0; k < 2; k++) begin offs[l][k] = k; negs[l][k] = 0; vds[l][k] = 1; end
    end
    run_job("all_void", 0, 0, 0, 2);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule